// File: doc/BRIEF.md
# Streamed Sector DMA Controller

This block streams sector data out of a read cache into system memory. Software first hands it a read command: a starting sector, a sector count and a sector format, either 2048 or 2340 bytes per sector. The controller at once asks the media side to load the first group of sectors into the cache. Software then programs a destination address and a byte length, sets the enable bit, and writes the start bit. From then on, every scheduling tick moves one bounded chunk of bytes from the cache to a 32-bit memory write port that uses a valid/ready handshake.

When the cache runs dry partway through a chunk and sectors are still outstanding, the controller asks for the next group of up to 32 sectors and carries on. The running address and the transferred length advance with every accepted beat. When the transferred length reaches the programmed length, the transfer stops and a DMA-end pulse is raised. When no sectors remain and the cache is empty, a command-done pulse tells the packet-command layer that the read has finished. Clearing the enable bit aborts a running transfer.

Top module: `sector_dma_ctrl`

## Requirements
- R1: A start write has no effect while the enable bit is 0: the active flag stays low and the running address keeps its value.
- R2: A start write with bit 0 set, made while enabled and with a valid length, sets the active flag, copies the programmed address into the running address and zeroes the running length.
- R3: A start is rejected, and the active flag stays low, when the programmed length is zero or any of its low 5 bits are set.
- R4: Writing 0 to the enable bit clears the active flag. After that no further beats are issued, no DMA-end pulse is raised, and later ticks move nothing.
- R5: One tick moves at most 10240 bytes. When no sectors remain outstanding, it also moves no more than the bytes left in the cache, and a tick that finds both at zero moves nothing.
- R6: Each accepted beat writes the cache word at the current cache byte offset to the running address. The running address and the running length each advance by 4 only on an accepted beat.
- R7: A refill request asks for min(remaining, 32) sectors starting at the current sector, in the command's format (`fill_long` 1 means 2340 bytes). On `fill_done` the cache holds count × size bytes from offset 0, the current sector advances by the count and the remaining count drops by it.
- R8: When the running length reaches the programmed length, the active flag clears and `dma_end_irq` pulses for one cycle.
- R9: At the end of a tick that leaves zero sectors outstanding and an empty cache, `cmd_done` pulses for one cycle.
- R10: While `dir_to_mem` is 0, a tick moves nothing and the running length is unchanged.
- R11: The programmed address and length registers are never changed by the controller and read back as written.
- R12: A read command taken while idle with a nonzero count clears the cache and requests the first refill without waiting for a tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en_we | input | 1 | Enable register write strobe |
| en_wdata | input | 1 | Enable value |
| start_we | input | 1 | Start register write strobe |
| start_wdata | input | 1 | Start value; only 1 acts |
| addr_we | input | 1 | Programmed address write strobe |
| addr_wdata | input | 32 | Programmed destination address |
| len_we | input | 1 | Programmed length write strobe |
| len_wdata | input | 32 | Programmed byte length |
| dir_to_mem | input | 1 | 1 selects device-to-memory, the only supported direction |
| tick | input | 1 | Scheduling tick, one-cycle pulse |
| cmd_valid | input | 1 | Read command strobe, taken while idle |
| cmd_sector | input | 24 | First sector of the read |
| cmd_count | input | 24 | Number of sectors |
| cmd_long | input | 1 | 1 selects 2340-byte sectors, 0 selects 2048 |
| fill_done | input | 1 | Media side has loaded the requested sectors |
| cache_rd_data | input | 32 | Cache word at `cache_rd_idx` |
| mw_ready | input | 1 | Memory accepts the current beat |
| en_q | output | 1 | Enable register |
| active_q | output | 1 | Transfer active flag |
| prog_addr_q | output | 32 | Programmed address readback |
| prog_len_q | output | 32 | Programmed length readback |
| run_addr_q | output | 32 | Running destination address |
| run_len_q | output | 32 | Bytes transferred so far |
| fill_req | output | 1 | Refill request, held until `fill_done` |
| fill_sector | output | 24 | First sector of the refill |
| fill_count | output | 6 | Sectors in the refill |
| fill_long | output | 1 | Sector format of the refill |
| cache_rd_idx | output | 17 | Byte offset of the next cache word |
| mw_valid | output | 1 | Memory write beat valid |
| mw_addr | output | 32 | Beat byte address |
| mw_data | output | 32 | Beat data |
| dma_end_irq | output | 1 | One-cycle pulse at programmed length |
| cmd_done | output | 1 | One-cycle pulse when the read has fully drained |

## Verification
The assertions assume that `fill_done` arrives only while `fill_req` is high, and therefore only into an empty cache with sectors outstanding. They also assume that no start write falls in the cycle of the final beat, and that read commands are issued only while the controller is idle. The bench respects all three. Its responder raises `fill_done` a few cycles after it sees a request. Each scenario waits until the port is quiet before it issues a new command or start. The stall pattern on `mw_ready` only lengthens beats and never lowers `mw_valid` from outside.

// File: rtl/sdma_pkg.sv
package sdma_pkg;

    localparam int unsigned SDMA_SEC_W      = 24;
    localparam int unsigned SDMA_CHUNK_MAX  = 10240;
    localparam int unsigned SDMA_FILL_MAX   = 32;
    localparam int unsigned SDMA_SEC_SHORT  = 2048;
    localparam int unsigned SDMA_SEC_LONG   = 2340;
    localparam int unsigned SDMA_ALIGN_BITS = 5;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_FILL = 2'd1,
        ST_XFER = 2'd2,
        ST_WRAP = 2'd3
    } xfer_state_e;

    typedef struct packed {
        logic [SDMA_SEC_W-1:0] sector;
        logic [SDMA_SEC_W-1:0] count;
        logic                  long_fmt;
    } rd_cmd_t;

    function automatic int unsigned sdma_max_u(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sdma_ctl_regs.sv
module sdma_ctl_regs
    import sdma_pkg::*;
#(
    parameter int unsigned ADDR_W     = 32,
    parameter int unsigned LEN_W      = 32,
    parameter int unsigned BEAT_BYTES = 4,
    parameter int unsigned ALIGN_BITS = SDMA_ALIGN_BITS
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en_we,
    input  logic              en_wd,
    input  logic              start_we,
    input  logic              start_wd,
    input  logic              addr_we,
    input  logic [ADDR_W-1:0] addr_wd,
    input  logic              len_we,
    input  logic [LEN_W-1:0]  len_wd,
    input  logic              beat,
    output logic              en_q,
    output logic              active_q,
    output logic [ADDR_W-1:0] prog_addr_q,
    output logic [LEN_W-1:0]  prog_len_q,
    output logic [ADDR_W-1:0] run_addr_q,
    output logic [LEN_W-1:0]  run_len_q,
    output logic [LEN_W-1:0]  left_len,
    output logic              end_irq_q
);

    logic len_ok;
    logic last_beat;

    assign len_ok    = (prog_len_q[ALIGN_BITS-1:0] == '0) && (prog_len_q != '0);
    assign left_len  = prog_len_q - run_len_q;
    assign last_beat = beat && active_q &&
                       ((run_len_q + LEN_W'(BEAT_BYTES)) == prog_len_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q        <= 1'b0;
            active_q    <= 1'b0;
            prog_addr_q <= '0;
            prog_len_q  <= '0;
            run_addr_q  <= '0;
            run_len_q   <= '0;
            end_irq_q   <= 1'b0;
        end else begin
            end_irq_q <= last_beat;
            if (addr_we) prog_addr_q <= addr_wd;
            if (len_we)  prog_len_q  <= len_wd;
            if (start_we && start_wd && en_q && len_ok) begin
                active_q   <= 1'b1;
                run_addr_q <= prog_addr_q;
                run_len_q  <= '0;
            end else if (beat && active_q) begin
                run_addr_q <= run_addr_q + ADDR_W'(BEAT_BYTES);
                run_len_q  <= run_len_q + LEN_W'(BEAT_BYTES);
                if (last_beat) active_q <= 1'b0;
            end
            if (en_we) begin
                en_q <= en_wd;
                if (!en_wd) active_q <= 1'b0;
            end
        end
    end

    AST_START_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
        (active_q && !$past(active_q)) |-> $past(en_q)); // R1

    AST_START_ALIGNED: assert property (@(posedge clk) disable iff (rst)
        (active_q && !$past(active_q)) |-> ($past(prog_len_q[ALIGN_BITS-1:0]) == '0)); // R3

    AST_ENABLE_GATES_ACTIVE: assert property (@(posedge clk) disable iff (rst)
        !en_q |-> !active_q); // R4

    AST_NO_OVERRUN: assert property (@(posedge clk) disable iff (rst)
        active_q |-> (run_len_q < prog_len_q)); // R8

    AST_IRQ_AT_LENGTH: assert property (@(posedge clk) disable iff (rst)
        end_irq_q |-> (run_len_q == prog_len_q && !active_q)); // R8

endmodule

// File: rtl/sdma_cache_trk.sv
module sdma_cache_trk
    import sdma_pkg::*;
#(
    parameter int unsigned FILL_MAX   = SDMA_FILL_MAX,
    parameter int unsigned SEC_SHORT  = SDMA_SEC_SHORT,
    parameter int unsigned SEC_LONG   = SDMA_SEC_LONG,
    parameter int unsigned BEAT_BYTES = 4,
    localparam int unsigned CNT_W     = $clog2(FILL_MAX + 1),
    localparam int unsigned CACHE_W   = $clog2(FILL_MAX * sdma_max_u(SEC_SHORT, SEC_LONG) + 1)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  cmd_take,
    input  rd_cmd_t               cmd,
    input  logic                  fill_done,
    input  logic                  beat,
    output logic [SDMA_SEC_W-1:0] remaining_q,
    output logic [CACHE_W-1:0]    cache_bytes_q,
    output logic [CACHE_W-1:0]    cache_idx_q,
    output logic [SDMA_SEC_W-1:0] fill_sector,
    output logic [CNT_W-1:0]      fill_count,
    output logic                  fill_long
);

    logic [SDMA_SEC_W-1:0] cur_sector_q;
    logic                  long_q;
    logic [CACHE_W-1:0]    sec_bytes;
    logic [CACHE_W-1:0]    fill_bytes;

    assign fill_count  = (remaining_q > SDMA_SEC_W'(FILL_MAX)) ? CNT_W'(FILL_MAX)
                                                                : remaining_q[CNT_W-1:0];
    assign sec_bytes   = long_q ? CACHE_W'(SEC_LONG) : CACHE_W'(SEC_SHORT);
    assign fill_bytes  = CACHE_W'(fill_count) * sec_bytes;
    assign fill_sector = cur_sector_q;
    assign fill_long   = long_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_sector_q  <= '0;
            remaining_q   <= '0;
            long_q        <= 1'b0;
            cache_bytes_q <= '0;
            cache_idx_q   <= '0;
        end else if (cmd_take) begin
            cur_sector_q  <= cmd.sector;
            remaining_q   <= cmd.count;
            long_q        <= cmd.long_fmt;
            cache_bytes_q <= '0;
            cache_idx_q   <= '0;
        end else if (fill_done) begin
            cache_bytes_q <= fill_bytes;
            cache_idx_q   <= '0;
            cur_sector_q  <= cur_sector_q + SDMA_SEC_W'(fill_count);
            remaining_q   <= remaining_q - SDMA_SEC_W'(fill_count);
        end else if (beat) begin
            cache_bytes_q <= cache_bytes_q - CACHE_W'(BEAT_BYTES);
            cache_idx_q   <= cache_idx_q + CACHE_W'(BEAT_BYTES);
        end
    end

    AST_CACHE_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (rst)
        beat |-> (cache_bytes_q >= CACHE_W'(BEAT_BYTES))); // R6

    AST_FILL_INTO_EMPTY: assert property (@(posedge clk) disable iff (rst)
        fill_done |-> (cache_bytes_q == '0 && remaining_q != '0)); // R7

    AST_FILL_GROUP_CAP: assert property (@(posedge clk) disable iff (rst)
        fill_done |=> (cache_bytes_q <= CACHE_W'(FILL_MAX * sdma_max_u(SEC_SHORT, SEC_LONG)))); // R7

endmodule

// File: rtl/sdma_xfer_fsm.sv
module sdma_xfer_fsm
    import sdma_pkg::*;
#(
    parameter int unsigned LEN_W      = 32,
    parameter int unsigned CHUNK_MAX  = SDMA_CHUNK_MAX,
    parameter int unsigned CACHE_W    = 17,
    parameter int unsigned BEAT_BYTES = 4,
    localparam int unsigned CHUNK_W   = $clog2(CHUNK_MAX + 1)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  tick,
    input  logic                  cmd_valid,
    input  logic                  cmd_count_nz,
    input  logic                  active,
    input  logic                  dir_to_mem,
    input  logic [LEN_W-1:0]      left_len,
    input  logic [SDMA_SEC_W-1:0] remaining,
    input  logic [CACHE_W-1:0]    cache_bytes,
    input  logic                  mw_ready,
    input  logic                  fill_done,
    output logic                  cmd_take,
    output logic                  mw_valid,
    output logic                  beat,
    output logic                  fill_req,
    output logic                  cmd_done
);

    xfer_state_e        state_q;
    logic [CHUNK_W-1:0] chunk_left_q;
    logic [CHUNK_W-1:0] chunk_cap;
    logic [CHUNK_W-1:0] chunk_new;
    logic               work_left;

    assign work_left = (remaining != '0) || (cache_bytes != '0);
    assign chunk_cap = (left_len > LEN_W'(CHUNK_MAX)) ? CHUNK_W'(CHUNK_MAX)
                                                      : left_len[CHUNK_W-1:0];

    always_comb begin
        chunk_new = chunk_cap;
        if (remaining == '0 && LEN_W'(cache_bytes) < LEN_W'(chunk_cap))
            chunk_new = cache_bytes[CHUNK_W-1:0];
    end

    assign cmd_take = (state_q == ST_IDLE) && cmd_valid;
    assign mw_valid = (state_q == ST_XFER) && active;
    assign beat     = mw_valid && mw_ready;
    assign fill_req = (state_q == ST_FILL);
    assign cmd_done = (state_q == ST_WRAP) && !work_left;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q      <= ST_IDLE;
            chunk_left_q <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (cmd_take) begin
                        chunk_left_q <= '0;
                        if (cmd_count_nz) state_q <= ST_FILL;
                    end else if (tick && active && dir_to_mem && work_left) begin
                        chunk_left_q <= chunk_new;
                        if (chunk_new == '0)        state_q <= ST_WRAP;
                        else if (cache_bytes == '0) state_q <= ST_FILL;
                        else                        state_q <= ST_XFER;
                    end
                end
                ST_FILL: begin
                    if (fill_done)
                        state_q <= (chunk_left_q != '0 && active) ? ST_XFER : ST_IDLE;
                end
                ST_XFER: begin
                    if (!active) begin
                        state_q      <= ST_IDLE;
                        chunk_left_q <= '0;
                    end else if (beat) begin
                        chunk_left_q <= chunk_left_q - CHUNK_W'(BEAT_BYTES);
                        if (chunk_left_q == CHUNK_W'(BEAT_BYTES))
                            state_q <= ST_WRAP;
                        else if (cache_bytes == CACHE_W'(BEAT_BYTES))
                            state_q <= (remaining != '0) ? ST_FILL : ST_WRAP;
                    end
                end
                ST_WRAP: state_q <= ST_IDLE;
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    AST_CHUNK_CAPPED: assert property (@(posedge clk) disable iff (rst)
        chunk_left_q <= CHUNK_W'(CHUNK_MAX)); // R5

    AST_DIR_BLOCKS_MOVE: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_IDLE && tick && !dir_to_mem && !cmd_valid) |=> (state_q == ST_IDLE)); // R10

    AST_BEAT_HELD: assert property (@(posedge clk) disable iff (rst)
        (mw_valid && !mw_ready) |=> (mw_valid || !active)); // R6

    AST_DONE_ONLY_DRAINED: assert property (@(posedge clk) disable iff (rst)
        cmd_done |-> (state_q == ST_WRAP && remaining == '0 && cache_bytes == '0)); // R9

endmodule

// File: rtl/sector_dma_ctrl.sv
module sector_dma_ctrl
    import sdma_pkg::*;
#(
    parameter int unsigned ADDR_W    = 32,
    parameter int unsigned LEN_W     = 32,
    parameter int unsigned DATA_W    = 32,
    parameter int unsigned CHUNK_MAX = SDMA_CHUNK_MAX,
    parameter int unsigned FILL_MAX  = SDMA_FILL_MAX,
    parameter int unsigned SEC_SHORT = SDMA_SEC_SHORT,
    parameter int unsigned SEC_LONG  = SDMA_SEC_LONG,
    localparam int unsigned BEAT_BYTES = DATA_W / 8,
    localparam int unsigned CNT_W      = $clog2(FILL_MAX + 1),
    localparam int unsigned CACHE_W    = $clog2(FILL_MAX * sdma_max_u(SEC_SHORT, SEC_LONG) + 1)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  en_we,
    input  logic                  en_wdata,
    input  logic                  start_we,
    input  logic                  start_wdata,
    input  logic                  addr_we,
    input  logic [ADDR_W-1:0]     addr_wdata,
    input  logic                  len_we,
    input  logic [LEN_W-1:0]      len_wdata,
    input  logic                  dir_to_mem,
    input  logic                  tick,
    input  logic                  cmd_valid,
    input  logic [SDMA_SEC_W-1:0] cmd_sector,
    input  logic [SDMA_SEC_W-1:0] cmd_count,
    input  logic                  cmd_long,
    input  logic                  fill_done,
    input  logic [DATA_W-1:0]     cache_rd_data,
    input  logic                  mw_ready,
    output logic                  en_q,
    output logic                  active_q,
    output logic [ADDR_W-1:0]     prog_addr_q,
    output logic [LEN_W-1:0]      prog_len_q,
    output logic [ADDR_W-1:0]     run_addr_q,
    output logic [LEN_W-1:0]      run_len_q,
    output logic                  fill_req,
    output logic [SDMA_SEC_W-1:0] fill_sector,
    output logic [CNT_W-1:0]      fill_count,
    output logic                  fill_long,
    output logic [CACHE_W-1:0]    cache_rd_idx,
    output logic                  mw_valid,
    output logic [ADDR_W-1:0]     mw_addr,
    output logic [DATA_W-1:0]     mw_data,
    output logic                  dma_end_irq,
    output logic                  cmd_done
);

    rd_cmd_t               cmd_bus;
    logic                  cmd_take;
    logic                  beat;
    logic [LEN_W-1:0]      left_len;
    logic [SDMA_SEC_W-1:0] remaining;
    logic [CACHE_W-1:0]    cache_bytes;

    assign cmd_bus = '{sector: cmd_sector, count: cmd_count, long_fmt: cmd_long};

    sdma_ctl_regs #(
        .ADDR_W(ADDR_W), .LEN_W(LEN_W), .BEAT_BYTES(BEAT_BYTES), .ALIGN_BITS(SDMA_ALIGN_BITS)
    ) u_regs (
        .clk(clk), .rst(rst),
        .en_we(en_we), .en_wd(en_wdata), .start_we(start_we), .start_wd(start_wdata),
        .addr_we(addr_we), .addr_wd(addr_wdata), .len_we(len_we), .len_wd(len_wdata),
        .beat(beat),
        .en_q(en_q), .active_q(active_q), .prog_addr_q(prog_addr_q), .prog_len_q(prog_len_q),
        .run_addr_q(run_addr_q), .run_len_q(run_len_q), .left_len(left_len),
        .end_irq_q(dma_end_irq)
    );

    sdma_cache_trk #(
        .FILL_MAX(FILL_MAX), .SEC_SHORT(SEC_SHORT), .SEC_LONG(SEC_LONG), .BEAT_BYTES(BEAT_BYTES)
    ) u_cache (
        .clk(clk), .rst(rst), .cmd_take(cmd_take), .cmd(cmd_bus),
        .fill_done(fill_done), .beat(beat),
        .remaining_q(remaining), .cache_bytes_q(cache_bytes), .cache_idx_q(cache_rd_idx),
        .fill_sector(fill_sector), .fill_count(fill_count), .fill_long(fill_long)
    );

    sdma_xfer_fsm #(
        .LEN_W(LEN_W), .CHUNK_MAX(CHUNK_MAX), .CACHE_W(CACHE_W), .BEAT_BYTES(BEAT_BYTES)
    ) u_fsm (
        .clk(clk), .rst(rst), .tick(tick), .cmd_valid(cmd_valid),
        .cmd_count_nz(cmd_count != '0), .active(active_q), .dir_to_mem(dir_to_mem),
        .left_len(left_len), .remaining(remaining), .cache_bytes(cache_bytes),
        .mw_ready(mw_ready), .fill_done(fill_done),
        .cmd_take(cmd_take), .mw_valid(mw_valid), .beat(beat),
        .fill_req(fill_req), .cmd_done(cmd_done)
    );

    assign mw_addr = run_addr_q;
    assign mw_data = cache_rd_data;

    AST_ADDR_HELD_ON_STALL: assert property (@(posedge clk) disable iff (rst)
        ($past(mw_valid && !mw_ready) && mw_valid) |-> $stable(mw_addr)); // R6

    AST_PROG_REGS_KEPT: assert property (@(posedge clk) disable iff (rst)
        (!$past(addr_we) && !$past(len_we)) |-> ($stable(prog_addr_q) && $stable(prog_len_q))); // R11

endmodule

// File: tb/sector_dma_ctrl_tb.sv
module sector_dma_ctrl_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        en_we = 0, en_wdata = 0, start_we = 0, start_wdata = 0;
    logic        addr_we = 0, len_we = 0;
    logic [31:0] addr_wdata = '0, len_wdata = '0;
    logic        dir_to_mem = 1'b1;
    logic        tick = 0;
    logic        cmd_valid = 0;
    logic [23:0] cmd_sector = '0, cmd_count = '0;
    logic        cmd_long = 0;
    logic        fill_done = 0;
    logic [31:0] cache_rd_data;
    logic        mw_ready = 1'b1;
    logic        en_q, active_q, fill_req, fill_long, mw_valid, dma_end_irq, cmd_done;
    logic [31:0] prog_addr_q, prog_len_q, run_addr_q, run_len_q, mw_addr, mw_data;
    logic [23:0] fill_sector;
    logic [5:0]  fill_count;
    logic [16:0] cache_rd_idx;

    int checks = 0, failures = 0;
    int beats = 0, mism = 0, irqs = 0, dones = 0, fills = 0;
    logic [23:0] last_fsec = '0, base_sec = '0;
    logic [5:0]  last_fcnt = '0;
    logic        last_flong = 0;
    logic        fill_busy = 0;
    int          fill_wait = 0;
    logic [31:0] exp_addr = '0;
    logic [16:0] exp_idx = '0;
    logic        stall_mode = 0;
    int          cyc = 0;

    always #4 clk = ~clk;

    assign cache_rd_data = {base_sec[14:0], cache_rd_idx};

    sector_dma_ctrl u_dut (
        .clk(clk), .rst(rst), .en_we(en_we), .en_wdata(en_wdata),
        .start_we(start_we), .start_wdata(start_wdata),
        .addr_we(addr_we), .addr_wdata(addr_wdata), .len_we(len_we), .len_wdata(len_wdata),
        .dir_to_mem(dir_to_mem), .tick(tick), .cmd_valid(cmd_valid),
        .cmd_sector(cmd_sector), .cmd_count(cmd_count), .cmd_long(cmd_long),
        .fill_done(fill_done), .cache_rd_data(cache_rd_data), .mw_ready(mw_ready),
        .en_q(en_q), .active_q(active_q), .prog_addr_q(prog_addr_q), .prog_len_q(prog_len_q),
        .run_addr_q(run_addr_q), .run_len_q(run_len_q), .fill_req(fill_req),
        .fill_sector(fill_sector), .fill_count(fill_count), .fill_long(fill_long),
        .cache_rd_idx(cache_rd_idx), .mw_valid(mw_valid), .mw_addr(mw_addr),
        .mw_data(mw_data), .dma_end_irq(dma_end_irq), .cmd_done(cmd_done)
    );

    // Memory sink, media responder and pulse counters, all on the falling edge.
    always @(negedge clk) begin
        cyc++;
        if (!rst) begin
            if (mw_valid && mw_ready) begin
                beats++;
                if (mw_addr !== exp_addr || mw_data !== {base_sec[14:0], exp_idx}) mism++;
                exp_addr = exp_addr + 32'd4;
                exp_idx  = exp_idx + 17'd4;
            end
            if (dma_end_irq) irqs++;
            if (cmd_done) dones++;
            fill_done = 1'b0;
            if (fill_req && !fill_busy) begin
                fill_busy = 1'b1;
                fill_wait = 3;
                fills++;
                last_fsec  = fill_sector;
                last_fcnt  = fill_count;
                last_flong = fill_long;
            end else if (fill_busy) begin
                if (fill_wait == 0) begin
                    fill_done = 1'b1;
                    fill_busy = 1'b0;
                    base_sec  = last_fsec;
                    exp_idx   = '0;
                end else begin
                    fill_wait--;
                end
            end
            mw_ready = stall_mode ? ((cyc % 3) != 0) : 1'b1;
        end
    end

    task automatic check(input string req, input string what, input logic [63:0] act,
                         input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic wr_en(input logic v);
        @(negedge clk); en_we = 1; en_wdata = v;
        @(negedge clk); en_we = 0;
    endtask

    task automatic wr_start();
        @(negedge clk); start_we = 1; start_wdata = 1;
        @(negedge clk); start_we = 0;
    endtask

    task automatic wr_prog(input logic [31:0] a, input logic [31:0] l);
        @(negedge clk); addr_we = 1; addr_wdata = a; len_we = 1; len_wdata = l;
        @(negedge clk); addr_we = 0; len_we = 0;
    endtask

    task automatic pulse_tick();
        @(negedge clk); tick = 1;
        @(negedge clk); tick = 0;
    endtask

    task automatic wait_quiet();
        int q = 0;
        while (q < 4) begin
            @(negedge clk);
            if (!mw_valid && !fill_req && !fill_busy) q++;
            else q = 0;
        end
    endtask

    task automatic issue_cmd(input logic [23:0] s, input logic [23:0] n, input logic lng);
        @(negedge clk); cmd_valid = 1; cmd_sector = s; cmd_count = n; cmd_long = lng;
        @(negedge clk); cmd_valid = 0;
        wait_quiet();
    endtask

    task automatic arm(input logic [31:0] a, input logic [31:0] l);
        wr_prog(a, l);
        wr_start();
        exp_addr = a;
    endtask

    task automatic t_reset();
        check("R2", "active after reset", active_q, 0);
        check("R1", "enable after reset", en_q, 0);
        check("R6", "valid after reset", mw_valid, 0);
        check("R7", "fill_req after reset", fill_req, 0);
        check("R6", "run_addr after reset", run_addr_q, 0);
    endtask

    task automatic t_start_disabled();
        wr_prog(32'h100, 32'd64);
        wr_start();
        check("R1", "active after start while disabled", active_q, 0);
        check("R1", "run_addr untouched", run_addr_q, 0);
    endtask

    task automatic t_bad_length();
        wr_en(1);
        wr_prog(32'h100, 32'd100);
        wr_start();
        check("R3", "active after unaligned length", active_q, 0);
        wr_prog(32'h100, 32'd0);
        wr_start();
        check("R3", "active after zero length", active_q, 0);
    endtask

    task automatic t_basic();
        int b0, i0, d0;
        issue_cmd(24'd100, 24'd2, 1'b0);
        check("R12", "fills after command", fills, 1);
        check("R7", "fill sector", last_fsec, 100);
        check("R7", "fill count", last_fcnt, 2);
        check("R7", "fill format", last_flong, 0);
        arm(32'h1000, 32'd4096);
        check("R2", "active after start", active_q, 1);
        check("R2", "run_addr copied", run_addr_q, 32'h1000);
        check("R2", "run_len cleared", run_len_q, 0);
        b0 = beats; i0 = irqs; d0 = dones;
        pulse_tick();
        wait_quiet();
        check("R6", "beats moved", beats - b0, 1024);
        check("R6", "address/data mismatches", mism, 0);
        check("R8", "dma_end pulses", irqs - i0, 1);
        check("R8", "active after length", active_q, 0);
        check("R6", "run_len final", run_len_q, 4096);
        check("R6", "run_addr final", run_addr_q, 32'h2000);
        check("R9", "cmd_done pulses", dones - d0, 1);
        check("R11", "prog_addr kept", prog_addr_q, 32'h1000);
        check("R11", "prog_len kept", prog_len_q, 4096);
    endtask

    task automatic t_chunk_cap();
        int b0, i0, d0;
        issue_cmd(24'd7, 24'd6, 1'b1);
        check("R7", "long fill count", last_fcnt, 6);
        check("R7", "long fill format", last_flong, 1);
        arm(32'h20000, 32'd14080);
        b0 = beats; i0 = irqs; d0 = dones;
        pulse_tick(); wait_quiet();
        check("R5", "first tick capped at 10240", beats - b0, 2560);
        check("R5", "run_len after first tick", run_len_q, 10240);
        b0 = beats;
        pulse_tick(); wait_quiet();
        check("R5", "second tick capped by cache bytes", beats - b0, 950);
        check("R5", "run_len after second tick", run_len_q, 14040);
        check("R9", "cmd_done when drained", dones - d0, 1);
        check("R8", "no dma_end short of length", irqs - i0, 0);
        check("R8", "still active short of length", active_q, 1);
        b0 = beats;
        pulse_tick(); wait_quiet();
        check("R5", "tick with nothing left moves nothing", beats - b0, 0);
        wr_en(0);
        check("R4", "active after enable cleared", active_q, 0);
        wr_en(1);
    endtask

    task automatic t_refill();
        int b0, i0, d0, f0;
        f0 = fills;
        issue_cmd(24'd1000, 24'd40, 1'b0);
        check("R7", "first group capped at 32", last_fcnt, 32);
        check("R7", "first group sector", last_fsec, 1000);
        arm(32'h40000, 32'd81920);
        b0 = beats; i0 = irqs; d0 = dones;
        for (int k = 0; k < 7; k++) begin
            pulse_tick(); wait_quiet();
        end
        check("R7", "refill issued mid chunk", fills - f0, 2);
        check("R7", "refill sector advanced", last_fsec, 1032);
        check("R7", "refill count is remainder", last_fcnt, 8);
        check("R5", "beats over seven ticks", beats - b0, 17920);
        pulse_tick(); wait_quiet();
        check("R8", "dma_end after refill run", irqs - i0, 1);
        check("R9", "cmd_done after refill run", dones - d0, 1);
        check("R6", "run_len after refill run", run_len_q, 81920);
        check("R6", "mismatches after refill run", mism, 0);
    endtask

    task automatic t_backpressure();
        int b0, i0;
        issue_cmd(24'd5, 24'd1, 1'b0);
        arm(32'h80000, 32'd2048);
        stall_mode = 1;
        b0 = beats; i0 = irqs;
        pulse_tick(); wait_quiet();
        stall_mode = 0;
        check("R6", "beats under stalls", beats - b0, 512);
        check("R6", "run_len under stalls", run_len_q, 2048);
        check("R6", "mismatches under stalls", mism, 0);
        check("R8", "dma_end under stalls", irqs - i0, 1);
    endtask

    task automatic t_direction();
        int b0;
        issue_cmd(24'd9, 24'd1, 1'b0);
        arm(32'h90000, 32'd2048);
        @(negedge clk); dir_to_mem = 0;
        b0 = beats;
        pulse_tick(); wait_quiet();
        check("R10", "beats with direction 0", beats - b0, 0);
        check("R10", "run_len with direction 0", run_len_q, 0);
        @(negedge clk); dir_to_mem = 1;
        pulse_tick(); wait_quiet();
        check("R10", "beats once direction restored", beats - b0, 512);
    endtask

    task automatic t_abort();
        int b0, i0, b1;
        issue_cmd(24'd20, 24'd4, 1'b0);
        arm(32'hA0000, 32'd8192);
        b0 = beats; i0 = irqs;
        pulse_tick();
        repeat (100) @(negedge clk);
        wr_en(0);
        wait_quiet();
        b1 = beats;
        check("R4", "active after abort", active_q, 0);
        check("R4", "abort cut the chunk short", (b1 - b0 > 0) && (b1 - b0 < 2048), 1);
        check("R4", "no dma_end after abort", irqs - i0, 0);
        pulse_tick(); wait_quiet();
        check("R4", "tick after abort moves nothing", beats - b1, 0);
        check("R6", "mismatches around abort", mism, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog R1..: actual=timeout expected=completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 0;
        @(negedge clk);
        t_reset();
        t_start_disabled();
        t_bad_length();
        t_basic();
        t_chunk_cap();
        t_refill();
        t_backpressure();
        t_direction();
        t_abort();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule